// File: doc/BRIEF.md
# Parallel Channel Service-Request Combiner

This block gathers the service requests of one parallel-port channel into a single summary request for the host. Two internal producers feed it. The first is the data pipeline, which raises an ordinary event (for example, tagged data arriving) and holds a data-error flag. The second is the channel control state machine, which reports up to six distinct causes. Each producer has its own enable controls. Each producer also owns a sticky status bit that the service routine clears by writing a one to it.

The summary bit is the OR of the two producer bits. It drives the interrupt output. It is also copied into a global service register, next to the DMA request lines, so a polling host can see every pending request kind with one read. Software reaches the block through a plain register port: a write strobe, a read strobe, an address and data. Read data is registered and appears one cycle after the read strobe.

Register addresses:

| Address | Register |
|---|---|
| 0 | Status |
| 1 | FIFO control |
| 2 | FIFO status |
| 3 | Cause enable |
| 4 | Cause |
| 5 | Global service |

Top module: `pchan_irq_agg`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq_o` is low.
- R2: Status bit 5 (pipeline) is set on the clock edge that samples `pipe_evt_i` high, but only while FIFO control bit 4 (normal enable) is one. If bit 4 is zero, the event leaves the bit unchanged.
- R3: A high `fifo_err_i` sets status bit 5 only when FIFO control bit 1 (error enable) and bit 4 are both one. Error enable alone has no effect. FIFO status (address 2) bit 0 reads `fifo_err_i`.
- R4: The cause register (address 4, bits 5:0) latches every high bit of `sm_cause_i` on the next clock edge. Writing a one to a bit clears it. A bit that is being set in the same cycle stays set.
- R5: Status bit 6 (channel) is set one cycle after any cause bit is one while its matching bit in the cause-enable register (address 3, bits 5:0) is also one. Masked causes never set it. Enabling an already pending cause sets it.
- R6: Status bit 7 (summary) and `irq_o` equal the OR of bits 5 and 6, delayed by one clock.
- R7: In the global service register (address 5), bit 3 reads the summary bit and bits 2:0 read `dma_req_i`.
- R8: Writing ones to status bits 5 and 6 clears them. Writing bit 7 has no effect. A request that is still active in the same cycle keeps its bit set.
- R9: `bus_rdata` holds the addressed register one cycle after `bus_rd`. FIFO control reads back all 8 written bits. Addresses 6 and 7 read zero. Writes to addresses 2 and 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pipe_evt_i | input | 1 | Pipeline normal-event pulse |
| fifo_err_i | input | 1 | Pipeline data-error flag |
| sm_cause_i | input | 6 | State-machine cause pulses |
| dma_req_i | input | 3 | DMA request lines, shown in the global service register |
| irq_o | output | 1 | Summary service request |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 3-bit address, six causes and three DMA lines.

These values bring every defined bit position within reach:
- the enable bits at positions 4 and 1;
- the status bits at positions 5 to 7;
- the mirror at bit 3 beside all three DMA lines;
- each cause lane.

They also leave two addresses undefined, so the zero-readback case can be tested. The vector walk combines enable settings with each source. The directed cases cover these conditions:
- the one-cycle summary lag;
- set-wins-over-clear;
- enabling a cause after it is already pending.

// File: rtl/pchan_pkg.sv
package pchan_pkg;
  // register addresses
  localparam int A_STAT  = 0;
  localparam int A_FCTL  = 1;
  localparam int A_FSTAT = 2;
  localparam int A_CEN   = 3;
  localparam int A_CAUSE = 4;
  localparam int A_GSVC  = 5;
  // bit positions decoded by software
  localparam int B_PIPE    = 5;
  localparam int B_CHAN    = 6;
  localparam int B_SUM     = 7;
  localparam int B_NORM_EN = 4;
  localparam int B_ERR_EN  = 1;
  localparam int B_DERR    = 0;
  localparam int B_GMIRROR = 3;
endpackage

// File: rtl/pchan_csr.sv
module pchan_csr
  import pchan_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 3,
  parameter int NCAUSE = 6,
  parameter int NDMA   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              pipe_bit,
  input  logic              chan_bit,
  input  logic              sum_bit,
  input  logic              fifo_err,
  input  logic [NCAUSE-1:0] cause_q,
  input  logic [NDMA-1:0]   dma_req,
  output logic              norm_en,
  output logic              err_en,
  output logic [NCAUSE-1:0] cause_en,
  output logic              clr_pipe,
  output logic              clr_chan,
  output logic [NCAUSE-1:0] cause_clr
);
  logic [DW-1:0]     fctl_q;
  logic [NCAUSE-1:0] cen_q;
  logic [DW-1:0]     rd_mux;
  logic              wr_stat, wr_fctl, wr_cen, wr_cause;

  assign wr_stat  = wr_en && (addr == AW'(A_STAT));
  assign wr_fctl  = wr_en && (addr == AW'(A_FCTL));
  assign wr_cen   = wr_en && (addr == AW'(A_CEN));
  assign wr_cause = wr_en && (addr == AW'(A_CAUSE));

  assign clr_pipe  = wr_stat && wdata[B_PIPE];
  assign clr_chan  = wr_stat && wdata[B_CHAN];
  assign cause_clr = wr_cause ? wdata[NCAUSE-1:0] : '0;

  assign norm_en  = fctl_q[B_NORM_EN];
  assign err_en   = fctl_q[B_ERR_EN];
  assign cause_en = cen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fctl_q <= '0;
      cen_q  <= '0;
    end else begin
      if (wr_fctl) fctl_q <= wdata;
      if (wr_cen)  cen_q  <= wdata[NCAUSE-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(A_STAT)) begin
      rd_mux[B_PIPE] = pipe_bit;
      rd_mux[B_CHAN] = chan_bit;
      rd_mux[B_SUM]  = sum_bit;
    end else if (addr == AW'(A_FCTL)) begin
      rd_mux = fctl_q;
    end else if (addr == AW'(A_FSTAT)) begin
      rd_mux[B_DERR] = fifo_err;
    end else if (addr == AW'(A_CEN)) begin
      rd_mux[NCAUSE-1:0] = cen_q;
    end else if (addr == AW'(A_CAUSE)) begin
      rd_mux[NCAUSE-1:0] = cause_q;
    end else if (addr == AW'(A_GSVC)) begin
      rd_mux[NDMA-1:0]    = dma_req;
      rd_mux[B_GMIRROR]   = sum_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/pchan_pipe_src.sv
module pchan_pipe_src (
  input  logic clk,
  input  logic rst,
  input  logic norm_en,
  input  logic err_en,
  input  logic evt,
  input  logic derr,
  input  logic clr,
  output logic pipe_bit
);
  logic req;
  // the error path rides on the normal enable
  assign req = norm_en && (evt || (err_en && derr));

  always_ff @(posedge clk) begin
    if (rst) pipe_bit <= 1'b0;
    else     pipe_bit <= req || (pipe_bit && !clr);
  end
endmodule

// File: rtl/pchan_cause_src.sv
module pchan_cause_src #(
  parameter int NCAUSE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:0] cause_in,
  input  logic [NCAUSE-1:0] cause_en,
  input  logic [NCAUSE-1:0] cause_clr,
  input  logic              clr_chan,
  output logic [NCAUSE-1:0] cause_q,
  output logic              chan_bit
);
  logic [NCAUSE-1:0] hit;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) cause_q[i] <= 1'b0;
      else     cause_q[i] <= cause_in[i] || (cause_q[i] && !cause_clr[i]);
    end
    assign hit[i] = cause_q[i] && cause_en[i];
  end

  always_ff @(posedge clk) begin
    if (rst) chan_bit <= 1'b0;
    else     chan_bit <= (|hit) || (chan_bit && !clr_chan);
  end
endmodule

// File: rtl/pchan_summary.sv
module pchan_summary (
  input  logic clk,
  input  logic rst,
  input  logic pipe_bit,
  input  logic chan_bit,
  output logic sum_bit
);
  always_ff @(posedge clk) begin
    if (rst) sum_bit <= 1'b0;
    else     sum_bit <= pipe_bit || chan_bit;
  end
endmodule

// File: rtl/pchan_irq_agg.sv
module pchan_irq_agg #(
  parameter int DW     = 8,
  parameter int AW     = 3,
  parameter int NCAUSE = 6,
  parameter int NDMA   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              pipe_evt_i,
  input  logic              fifo_err_i,
  input  logic [NCAUSE-1:0] sm_cause_i,
  input  logic [NDMA-1:0]   dma_req_i,
  output logic              irq_o
);
  logic              norm_en, err_en;
  logic [NCAUSE-1:0] cause_en, cause_clr, cause_q;
  logic              clr_pipe, clr_chan;
  logic              pipe_bit, chan_bit, sum_bit;

  pchan_csr #(.DW(DW), .AW(AW), .NCAUSE(NCAUSE), .NDMA(NDMA)) u_csr (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .pipe_bit(pipe_bit),
    .chan_bit(chan_bit), .sum_bit(sum_bit), .fifo_err(fifo_err_i),
    .cause_q(cause_q), .dma_req(dma_req_i), .norm_en(norm_en),
    .err_en(err_en), .cause_en(cause_en), .clr_pipe(clr_pipe),
    .clr_chan(clr_chan), .cause_clr(cause_clr)
  );

  pchan_pipe_src u_pipe (
    .clk(clk), .rst(rst), .norm_en(norm_en), .err_en(err_en),
    .evt(pipe_evt_i), .derr(fifo_err_i), .clr(clr_pipe), .pipe_bit(pipe_bit)
  );

  pchan_cause_src #(.NCAUSE(NCAUSE)) u_cause (
    .clk(clk), .rst(rst), .cause_in(sm_cause_i), .cause_en(cause_en),
    .cause_clr(cause_clr), .clr_chan(clr_chan), .cause_q(cause_q),
    .chan_bit(chan_bit)
  );

  pchan_summary u_sum (
    .clk(clk), .rst(rst), .pipe_bit(pipe_bit), .chan_bit(chan_bit),
    .sum_bit(sum_bit)
  );

  assign irq_o = sum_bit;
endmodule

// File: rtl/pchan_irq_chk.sv
module pchan_irq_chk #(
  parameter int DW     = 8,
  parameter int AW     = 3,
  parameter int NCAUSE = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_rdata,
  input logic [NCAUSE-1:0] sm_cause_i,
  input logic              irq_o,
  input logic              norm_en,
  input logic              pipe_bit,
  input logic              chan_bit,
  input logic [NCAUSE-1:0] cause_q,
  input logic [NCAUSE-1:0] cause_en
);
  assert_pipe_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (!norm_en && !pipe_bit) |=> !pipe_bit);

  assert_cause_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (sm_cause_i != '0) |=> ((cause_q & $past(sm_cause_i)) == $past(sm_cause_i)));

  assert_chan_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (((cause_q & cause_en) == '0) && !chan_bit) |=> !chan_bit);

  assert_summary_lag_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(pipe_bit || chan_bit)));

  assert_mirror_read_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(5)) |=> (bus_rdata[3] == $past(irq_o)));
endmodule

bind pchan_irq_agg pchan_irq_chk #(.DW(DW), .AW(AW), .NCAUSE(NCAUSE)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .sm_cause_i(sm_cause_i), .irq_o(irq_o),
  .norm_en(norm_en), .pipe_bit(pipe_bit), .chan_bit(chan_bit),
  .cause_q(cause_q), .cause_en(cause_en)
);

// File: tb/sim_pchan_irq_agg.sv
`timescale 1ns/1ps
module sim_pchan_irq_agg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pipe_evt_i = 1'b0, fifo_err_i = 1'b0;
  logic [5:0] sm_cause_i = '0;
  logic [2:0] dma_req_i = '0;
  logic       irq_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pchan_irq_agg u0 (.*);

  typedef struct packed {
    logic [7:0] fcr;
    logic [5:0] cen;
    logic       evt;
    logic       err;
    logic [5:0] cause;
    logic [7:0] exp_stat;
  } vec_t;

  // pipe only = A0, chan only = C0, both = E0
  localparam vec_t VEC [8] = '{
    '{8'h10, 6'h00, 1'b1, 1'b0, 6'h00, 8'hA0},  // R2 enabled event
    '{8'h00, 6'h00, 1'b1, 1'b0, 6'h00, 8'h00},  // R2 disabled event
    '{8'h12, 6'h00, 1'b0, 1'b1, 6'h00, 8'hA0},  // R3 both enables
    '{8'h02, 6'h00, 1'b0, 1'b1, 6'h00, 8'h00},  // R3 error enable alone
    '{8'h10, 6'h00, 1'b0, 1'b1, 6'h00, 8'h00},  // R3 normal enable alone
    '{8'h00, 6'h04, 1'b0, 1'b0, 6'h04, 8'hC0},  // R5 enabled cause
    '{8'h00, 6'h3B, 1'b0, 1'b0, 6'h04, 8'h00},  // R5 masked cause
    '{8'h10, 6'h20, 1'b1, 1'b0, 6'h21, 8'hE0}   // R5 R6 both sources
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    wr(3'd4, 8'h3F); wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h60);
    idle(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      check($sformatf("R1 reset addr %0d", a), d, 8'h00);
    end
    check("R1 irq reset", {7'b0, irq_o}, 8'h00);

    // vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, VEC[i].fcr);
      wr(3'd3, {2'b00, VEC[i].cen});
      @(negedge clk);
      pipe_evt_i = VEC[i].evt; fifo_err_i = VEC[i].err; sm_cause_i = VEC[i].cause;
      @(negedge clk);
      pipe_evt_i = 1'b0; fifo_err_i = 1'b0; sm_cause_i = '0;
      idle(3);
      rd(3'd0, d);
      check($sformatf("R2 R3 R5 R6 vec %0d status", i), d, VEC[i].exp_stat);
      rd(3'd4, d);
      check($sformatf("R4 vec %0d cause", i), d, {2'b00, VEC[i].cause});
      check($sformatf("R6 vec %0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i].exp_stat[7]});
      cleanup();
      rd(3'd0, d);
      check($sformatf("R8 vec %0d cleared", i), d, 8'h00);
    end

    // R6 one-cycle lag on set and clear
    wr(3'd1, 8'h10);
    @(negedge clk); pipe_evt_i = 1'b1;
    @(negedge clk); pipe_evt_i = 1'b0;
    check("R6 irq lags set", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    check("R6 irq after set", {7'b0, irq_o}, 8'h01);
    wr(3'd0, 8'h20);
    check("R6 irq lags clear", {7'b0, irq_o}, 8'h01);
    @(negedge clk);
    check("R6 irq after clear", {7'b0, irq_o}, 8'h00);
    cleanup();

    // R7 global mirror with DMA lines, R8 bit7 write ignored
    dma_req_i = 3'b101;
    wr(3'd3, 8'h01);
    @(negedge clk); sm_cause_i = 6'h01;
    @(negedge clk); sm_cause_i = '0;
    idle(3);
    rd(3'd5, d);
    check("R7 global with summary", d, 8'h0D);
    wr(3'd0, 8'h80);
    idle(1);
    rd(3'd0, d);
    check("R8 bit7 write ignored", d, 8'hC0);
    cleanup();
    rd(3'd5, d);
    check("R7 global without summary", d, 8'h05);
    dma_req_i = 3'b000;

    // R8 set wins over clear while error persists
    wr(3'd1, 8'h12);
    fifo_err_i = 1'b1;
    idle(3);
    wr(3'd0, 8'h20);
    rd(3'd0, d);
    check("R8 active request keeps bit", d, 8'hA0);
    rd(3'd2, d);
    check("R3 fifo status readback", d, 8'h01);
    fifo_err_i = 1'b0;
    cleanup();

    // R5 enabling an already pending cause
    @(negedge clk); sm_cause_i = 6'h08;
    @(negedge clk); sm_cause_i = '0;
    idle(3);
    rd(3'd0, d);
    check("R5 pending masked", d, 8'h00);
    wr(3'd3, 8'h08);
    idle(3);
    rd(3'd0, d);
    check("R5 late enable", d, 8'hC0);
    cleanup();

    // R4 write-one-to-clear of causes
    @(negedge clk); sm_cause_i = 6'h3F;
    @(negedge clk); sm_cause_i = '0;
    wr(3'd4, 8'h05);
    rd(3'd4, d);
    check("R4 partial clear", d, 8'h3A);
    cleanup();

    // R9 readback and ignored writes
    wr(3'd1, 8'hA5);
    rd(3'd1, d);
    check("R9 control readback", d, 8'hA5);
    rd(3'd7, d);
    check("R9 undefined address", d, 8'h00);
    wr(3'd2, 8'hFF);
    rd(3'd2, d);
    check("R9 fifo status write ignored", d, 8'h00);
    wr(3'd5, 8'hFF);
    rd(3'd5, d);
    check("R9 global write ignored", d, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule